// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs one serial-flash transaction each time software asks for it. Software uses a byte-wide register port to fill a buffer of byte slots. The slots sit eight addresses apart. Slots 0 and 1 hold a 16-bit count of serial clocks, with the high byte first. From slot 2 (address 0x010) onward, the slots hold the bytes to send: first the command byte, then any address bytes, then the payload.

Writing 0xFF to the start address launches the transfer. The engine pulls chip select low, toggles the serial clock exactly the programmed number of times, and shifts the buffer out least-significant bit first. Returned bits are gathered into the buffer one slot further on, so software reads each reply byte one slot after the byte that was being sent when it arrived. Because the shift order is LSB first, software bit-reverses standard opcodes and address bytes before loading them.

A busy byte at address 0x001 tells software when the buffer may be read or reloaded. The register port is a plain write strobe plus a combinational read. It has no handshake and never applies back-pressure. While a transfer runs, the engine drops every write, so software must poll busy before touching the buffer.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, busy reads 0x00, chip select is high, the serial clock is low, data out is low, and every buffer slot reads 0x00.
- R2: Slot k (k from 0 to 254) is written and read at byte address 8*k. The clock count high byte is at 0x000, the low byte at 0x008, and the first stream byte at 0x010. A read at any address whose three low bits are nonzero, other than 0x001, returns 0x00.
- R3: A transfer starts only when the byte 0xFF is written to 0x7F8 while idle with a nonzero count. Any other value written there does nothing. Address 0x001 reads 0x01 while a transfer runs and 0x00 otherwise.
- R4: A transfer of N clocks gives exactly N rising serial clock edges, with N taken from both count bytes. Busy stays set for (N-1)*DIV + DIV/2 + 2 system cycles, counted from the cycle after the accepting edge.
- R5: Chip select falls one system cycle before the first rising serial clock edge and rises one cycle after the last falling edge. Each serial clock high phase and low phase lasts DIV/2 system cycles.
- R6: The transmitted bit stream is slot 2, then slot 3, then slot 4, and so on, each byte LSB first. Data out is valid when chip select falls and changes only on falling serial clock edges.
- R7: The bit sampled at rising edge j of byte k is stored into bit j%8 of slot 3+k (address 0x18+8k) when that byte ends or the transfer ends. In a partial final byte, the bits not received read as 0. Slot 3+k is still sent with its value from before the transfer, and slots past the last received byte keep their contents.
- R8: While busy, writes to the buffer, the count and the start address are all ignored. The transfer in progress keeps its length and data, and no second transfer follows.
- R9: A start with a count of zero never drops chip select and never sets busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 11 | Register write byte address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 11 | Register read byte address |
| rd_data | output | 8 | Register read data, combinational |
| busy | output | 1 | High while a transfer runs |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_clk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The transfer path is exercised with clock counts of 8, 12, 16, 40 and 48, and with 264 (0x0108), which needs the high count byte. Single-byte and multi-byte runs separate the byte-boundary reload from the within-byte shift. The 12-clock run exposes partial-byte handling. The 40-clock run checks that a reply lands at 0x038, and the long run checks the 16-bit count path. The flash model answers with distinct per-byte patterns, so a receive byte stored one slot off, or a slot sent after it was overwritten, shows up as a mismatch. Directed cases cover a wrong start value, a zero count, and writes plus a second start issued mid-transfer.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL
  } seq_state_t;

  localparam int SLOT_SHIFT  = 3;
  localparam int CNT_HI_SLOT = 0;
  localparam int CNT_LO_SLOT = 1;
  localparam int CMD_SLOT    = 2;
  localparam int BUSY_ADDR   = 1;
  localparam logic [7:0] GO_CODE = 8'hFF;
endpackage

// File: rtl/fe_buffer.sv
module fe_buffer
  import flash_eng_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_waddr,
  input  logic [7:0]                    bus_wdata,
  input  logic [ADDR_W-1:0]             bus_raddr,
  output logic [7:0]                    bus_rdata,
  input  logic                          busy,
  output logic                          start,
  output logic [15:0]                   clk_count,
  input  logic [ADDR_W-SLOT_SHIFT-1:0]  eng_rslot,
  output logic [7:0]                    eng_rdata,
  input  logic                          eng_we,
  input  logic [ADDR_W-SLOT_SHIFT-1:0]  eng_wslot,
  input  logic [7:0]                    eng_wdata
);
  localparam int SLOT_W = ADDR_W - SLOT_SHIFT;
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int MEM_N  = SLOTS - 1;
  localparam logic [SLOT_W-1:0] GO_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [ADDR_W-1:0] GO_ADDR = {GO_SLOT, {SLOT_SHIFT{1'b0}}};

  logic [7:0] mem [MEM_N];

  logic              w_aligned, r_aligned;
  logic [SLOT_W-1:0] w_slot, r_slot;

  assign w_aligned = (bus_waddr[SLOT_SHIFT-1:0] == '0);
  assign r_aligned = (bus_raddr[SLOT_SHIFT-1:0] == '0);
  assign w_slot    = bus_waddr[ADDR_W-1:SLOT_SHIFT];
  assign r_slot    = bus_raddr[ADDR_W-1:SLOT_SHIFT];

  assign start = bus_we && !busy && (bus_waddr == GO_ADDR) && (bus_wdata == GO_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= '0;
    end else if (bus_we && !busy && w_aligned && (w_slot != GO_SLOT)) begin
      mem[w_slot] <= bus_wdata;
    end else if (eng_we && (eng_wslot > SLOT_W'(CMD_SLOT)) && (eng_wslot != GO_SLOT)) begin
      mem[eng_wslot] <= eng_wdata;
    end
  end

  assign clk_count = {mem[CNT_HI_SLOT], mem[CNT_LO_SLOT]};
  assign eng_rdata = (eng_rslot == GO_SLOT) ? 8'h00 : mem[eng_rslot];

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_raddr == ADDR_W'(BUSY_ADDR))
      bus_rdata = {7'b0, busy};
    else if (r_aligned && (r_slot != GO_SLOT))
      bus_rdata = mem[r_slot];
  end

  // R8: a bus write during a transfer leaves the command slot untouched
  p_frozen_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we) |=> $stable(mem[CMD_SLOT]));

  // R4: the programmed length cannot change once a transfer is under way
  p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(clk_count));
endmodule

// File: rtl/fe_shifter.sv
module fe_shifter
  import flash_eng_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       clk_count,
  output logic [SLOT_W-1:0] eng_rslot,
  input  logic [7:0]        eng_rdata,
  output logic              eng_we,
  output logic [SLOT_W-1:0] eng_wslot,
  output logic [7:0]        eng_wdata,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int HALF = DIV / 2;
  localparam int PH_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF - 1);

  seq_state_t        state;
  logic [15:0]       total, done_clk, nd;
  logic [PH_W-1:0]   ph;
  logic [SLOT_W-1:0] slot, slot_nx;
  logic [7:0]        tx_sh, rx_sh;
  logic              cs_n_q, sclk_q, fall;

  assign nd        = done_clk + 16'd1;
  assign slot_nx   = slot + SLOT_W'(1);
  assign fall      = (state == ST_SHIFT) && (ph == PH_LAST) && sclk_q;
  assign eng_rslot = (state == ST_IDLE) ? SLOT_W'(CMD_SLOT) : slot_nx;
  assign eng_we    = fall && ((nd[2:0] == 3'd0) || (nd == total));
  assign eng_wslot = slot_nx;
  assign eng_wdata = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      total    <= '0;
      done_clk <= '0;
      ph       <= '0;
      slot     <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      cs_n_q   <= 1'b1;
      sclk_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start && (clk_count != 16'd0)) begin
          state    <= ST_LEAD;
          cs_n_q   <= 1'b0;
          total    <= clk_count;
          done_clk <= '0;
          slot     <= SLOT_W'(CMD_SLOT);
          tx_sh    <= eng_rdata;
          rx_sh    <= '0;
          ph       <= '0;
        end
        ST_LEAD: begin
          state    <= ST_SHIFT;
          sclk_q   <= 1'b1;
          rx_sh[0] <= miso;
          ph       <= '0;
        end
        ST_SHIFT: if (ph == PH_LAST) begin
          ph <= '0;
          if (sclk_q) begin
            sclk_q   <= 1'b0;
            done_clk <= nd;
            if (nd == total) begin
              state <= ST_TAIL;
            end else if (nd[2:0] == 3'd0) begin
              slot  <= slot_nx;
              tx_sh <= eng_rdata;
              rx_sh <= '0;
            end else begin
              tx_sh <= tx_sh >> 1;
            end
          end else begin
            sclk_q               <= 1'b1;
            rx_sh[done_clk[2:0]] <= miso;
          end
        end else begin
          ph <= ph + PH_W'(1);
        end
        ST_TAIL: begin
          cs_n_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign cs_n = cs_n_q;
  assign sclk = sclk_q;
  assign mosi = busy ? tx_sh[0] : 1'b0;

  // R1: between transfers the serial lines rest
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!sclk_q && cs_n_q));

  // R5: chip select leads the first rising clock by one cycle
  p_lead_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> (!sclk_q ##1 sclk_q));

  // R4: chip select is released only after the full clock count
  p_clock_total_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> (done_clk == total));

  // R9: a zero-length start leaves the engine idle
  p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && clk_count == 16'd0) |=> (state == ST_IDLE));

  // R6: data out holds still across every rising clock edge
  p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(mosi));
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_eng_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              spi_cs_n,
  output logic              spi_clk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

  logic              start, eng_we;
  logic [15:0]       clk_count;
  logic [SLOT_W-1:0] eng_rslot, eng_wslot;
  logic [7:0]        eng_rdata, eng_wdata;

  fe_buffer #(.ADDR_W(ADDR_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (wr_en),
    .bus_waddr (wr_addr),
    .bus_wdata (wr_data),
    .bus_raddr (rd_addr),
    .bus_rdata (rd_data),
    .busy      (busy),
    .start     (start),
    .clk_count (clk_count),
    .eng_rslot (eng_rslot),
    .eng_rdata (eng_rdata),
    .eng_we    (eng_we),
    .eng_wslot (eng_wslot),
    .eng_wdata (eng_wdata)
  );

  fe_shifter #(.DIV(DIV), .SLOT_W(SLOT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .clk_count (clk_count),
    .eng_rslot (eng_rslot),
    .eng_rdata (eng_rdata),
    .eng_we    (eng_we),
    .eng_wslot (eng_wslot),
    .eng_wdata (eng_wdata),
    .busy      (busy),
    .cs_n      (spi_cs_n),
    .sclk      (spi_clk),
    .mosi      (spi_mosi),
    .miso      (spi_miso)
  );
endmodule

// File: tb/flash_cmd_engine_test.sv
module flash_cmd_engine_test;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [10:0] wr_addr = '0;
  logic [10:0] rd_addr = '0;
  logic [7:0]  wr_data = '0;
  wire  [7:0]  rd_data;
  wire         busy, spi_cs_n, spi_clk, spi_mosi, spi_miso;

  always #10 clk = ~clk;

  flash_cmd_engine #(.ADDR_W(11), .DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .spi_cs_n(spi_cs_n),
    .spi_clk(spi_clk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_chk = 0;
  int n_fail = 0;

  // flash model and edge bookkeeping
  int unsigned cyc = 0;
  int unsigned rcnt = 0;
  int rises = 0, cs_falls = 0, width_bad = 0;
  int cs_fall_cyc = 0, cs_rise_cyc = 0, first_rise_cyc = 0, last_rise_cyc = 0, last_fall_cyc = 0;
  logic [47:0] resp = '0;
  logic [63:0] seen = '0;

  always @(posedge clk) cyc++;
  assign spi_miso = (rcnt < 48) ? resp[rcnt] : 1'b1;

  always @(negedge spi_cs_n) begin
    rcnt = 0; rises = 0; seen = '0; cs_fall_cyc = cyc; cs_falls++;
  end
  always @(posedge spi_cs_n) cs_rise_cyc = cyc;
  always @(posedge spi_clk) begin
    if (rises == 0) first_rise_cyc = cyc;
    else if (cyc - last_fall_cyc != HALF) width_bad++;
    last_rise_cyc = cyc;
    if (rcnt < 64) seen[rcnt] = spi_mosi;
    rises++;
    rcnt++;
  end
  always @(negedge spi_clk) begin
    if (cyc - last_rise_cyc != HALF) width_bad++;
    last_fall_cyc = cyc;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_byte(input logic [10:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_idle(output int bc);
    logic [7:0] b;
    bc = 0;
    rd_byte(11'h001, b);
    while (b != 8'h00 && bc < 5000) begin
      bc++;
      @(negedge clk);
      rd_byte(11'h001, b);
    end
  endtask

  typedef struct packed {
    logic [15:0] n;
    logic [47:0] tx;
    logic [47:0] rsp;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{16'd8,  48'h0605040302C7, 48'h0000000000A9},
    '{16'd16, 48'h000000000005, 48'h000000008100},
    '{16'd40, 48'h0000000000AB, 48'h005AFFFFFF00},
    '{16'd12, 48'h00000000C35A, 48'h00000000A53C},
    '{16'd48, 48'h804020100803, 48'hDEADBEEF1234}
  };

  task automatic run_vec(input vec_t v);
    int bc, nb, rem;
    logic [7:0]  b, bm;
    logic [47:0] m;
    bus_wr(11'h000, v.n[15:8]);
    bus_wr(11'h008, v.n[7:0]);
    for (int j = 0; j < 6; j++) bus_wr(11'((2 + j) * 8), v.tx[8*j +: 8]);
    resp = v.rsp;
    bus_wr(11'h7F8, 8'hFF);
    wait_idle(bc);
    nb = (int'(v.n) + 7) / 8;
    m  = (v.n >= 48) ? '1 : ((48'h1 << v.n) - 48'h1);
    chk("R4 clock count", 64'(rises), 64'(v.n));
    chk("R4 busy length", 64'(bc), 64'((int'(v.n) - 1) * DIV + HALF + 2));
    chk("R5 cs lead", 64'(first_rise_cyc - cs_fall_cyc), 64'd1);
    chk("R5 cs tail", 64'(cs_rise_cyc - last_fall_cyc), 64'd1);
    chk("R5 phase widths", 64'(width_bad), 64'd0);
    chk("R6 tx stream", 64'(seen[47:0] & m), 64'(v.tx & m));
    for (int k = 0; k < nb; k++) begin
      rem = int'(v.n) - 8 * k;
      bm  = (rem >= 8) ? 8'hFF : 8'((9'h1 << rem) - 9'h1);
      rd_byte(11'((3 + k) * 8), b);
      chk("R7 rx slot", 64'(b), 64'(v.rsp[8*k +: 8] & bm));
    end
    rd_byte(11'h010, b);
    chk("R7 cmd slot kept", 64'(b), 64'(v.tx[7:0]));
    if (nb + 1 < 6) begin
      rd_byte(11'((3 + nb) * 8), b);
      chk("R7 later slot kept", 64'(b), 64'(v.tx[8*(nb+1) +: 8]));
    end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] b;
    int bc, falls0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_byte(11'h001, b);    chk("R1 busy", 64'(b), 64'h0);
    chk("R1 lines", 64'({spi_cs_n, spi_clk, spi_mosi}), 64'b100);
    rd_byte(11'h010, b);    chk("R1 cmd slot", 64'(b), 64'h0);
    rd_byte(11'h7F0, b);    chk("R1 last slot", 64'(b), 64'h0);

    // R2 map readback and unmapped reads
    bus_wr(11'h028, 8'h6B);
    rd_byte(11'h028, b);    chk("R2 readback", 64'(b), 64'h6B);
    bus_wr(11'h02C, 8'h77);
    rd_byte(11'h02C, b);    chk("R2 unaligned read", 64'(b), 64'h0);
    rd_byte(11'h028, b);    chk("R2 unaligned write", 64'(b), 64'h6B);

    // R3 wrong start code does nothing
    bus_wr(11'h008, 8'd8);
    falls0 = cs_falls;
    bus_wr(11'h7F8, 8'hFE);
    repeat (4) @(negedge clk);
    rd_byte(11'h001, b);    chk("R3 wrong code busy", 64'(b), 64'h0);
    chk("R3 wrong code cs", 64'(cs_falls - falls0), 64'd0);

    // R9 zero count
    bus_wr(11'h008, 8'd0);
    bus_wr(11'h7F8, 8'hFF);
    rd_byte(11'h001, b);    chk("R9 zero busy", 64'(b), 64'h0);
    repeat (4) @(negedge clk);
    chk("R9 zero cs", 64'(cs_falls - falls0), 64'd0);

    // table of transfers: R4 R5 R6 R7
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R8 writes and a second start during busy
    bus_wr(11'h000, 8'd0);
    bus_wr(11'h008, 8'd16);
    bus_wr(11'h010, 8'h99);
    falls0 = cs_falls;
    bus_wr(11'h7F8, 8'hFF);
    rd_byte(11'h001, b);    chk("R3 busy flag set", 64'(b), 64'h01);
    bus_wr(11'h010, 8'h11);
    bus_wr(11'h000, 8'h05);
    bus_wr(11'h7F8, 8'hFF);
    wait_idle(bc);
    repeat (10) @(negedge clk);
    rd_byte(11'h001, b);    chk("R8 no second run", 64'(b), 64'h0);
    chk("R8 single cs", 64'(cs_falls - falls0), 64'd1);
    chk("R8 length kept", 64'(rises), 64'd16);
    rd_byte(11'h010, b);    chk("R8 cmd kept", 64'(b), 64'h99);
    rd_byte(11'h000, b);    chk("R8 count kept", 64'(b), 64'h00);

    // R4 long count through the high byte
    bus_wr(11'h000, 8'h01);
    bus_wr(11'h008, 8'h08);
    bus_wr(11'h7F8, 8'hFF);
    wait_idle(bc);
    chk("R4 long clocks", 64'(rises), 64'd264);
    chk("R4 long busy", 64'(bc), 64'(263 * DIV + HALF + 2));

    finish_up();
  end
endmodule